// File: doc/BRIEF.md
# Bridge Power Mode Controller

This block steps a bridge device between a fully powered state and four reduced-power states: a light state (doze), a deeper state that also parks the processor (nap), a deepest state where almost nothing runs (sleep), and an externally forced state (suspend). Software picks doze, nap or sleep by setting one of three request bits. An external pin forces suspend. The block drives four enable lines, one for each functional group: PCI address decoding, DRAM refresh, bus-request monitoring, and the rest of the core. It also drives a quiesce acknowledge and an output high-impedance enable.

While the bridge is in doze or nap, the block watches for wake events: a PCI transaction aimed at system memory, or a processor bus request. On a wake it enters a service state with every group enabled. When the access completes, it decides where to go next. After doze it always goes back to doze. After nap it goes back to nap only if a PCI access caused the wake; a processor wake leaves the bridge fully on. A synchronous hard-reset input brings the bridge back to full-on from any state except suspend. In suspend, every input except the suspend pin is ignored.

A low-power request is accepted only once the bus has been idle for a programmable number of consecutive cycles. A request is also accepted only while the controller is armed. Arming happens whenever all request bits read zero. Reset, hard reset, leaving sleep, leaving suspend, and a processor wake from nap all clear the arm.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After `rstN` is released, `curMode` is 0 (full-on), all four group enables are 1, and `quiesceAck` and `outHiZ` are 0.
- R2: `modeReq` bit 0 requests doze, bit 1 requests nap and bit 2 requests sleep. When several bits are set, sleep wins over nap and nap wins over doze.
- R3: Entry from full-on into a requested mode happens only on a clock edge where `busBusy` is low and was also low on the preceding IDLE_CYCLES-1 edges. While `busBusy` stays high, the controller remains in full-on.
- R4: In doze (`curMode` 1) and nap (`curMode` 2), `enPciDecode`, `enRefresh` and `enBusReqMon` are 1 and `enCore` is 0.
- R5: In sleep (`curMode` 3), `enRefresh` follows `sleepRefreshEn`, and the other three enables are 0.
- R6: In doze, `pciMemHit` or `cpuBusReq` moves the controller to service (`curMode` 5) with all enables 1. On `accessDone` it returns to doze if `modeReq` is nonzero, and to full-on otherwise.
- R7: From nap, a PCI wake returns to nap on `accessDone`. A processor wake (`cpuBusReq`, which wins when both are seen together) returns to full-on and disarms. A nap request is then honoured only after `modeReq` has read zero.
- R8: In sleep, `pciMemHit` has no effect. Only `cpuBusReq` (to full-on) or `hardRst` wakes the controller.
- R9: A high `suspendPin` that has passed through SYNC_STAGES flops forces suspend (`curMode` 4) from any state. In suspend, `enRefresh` and `outHiZ` are 1, the other enables are 0, and `hardRst` and the other inputs are ignored. When the pin goes low, the controller moves to full-on.
- R10: Outside suspend, `hardRst` returns the controller to full-on on the next edge and clears the arm.
- R11: `quiesceAck` is 1 exactly while the controller is in nap or sleep.
- R12: `curMode` encodes 0 full-on, 1 doze, 2 nap, 3 sleep, 4 suspend, 5 service. It changes on the same edge as the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| hardRst | input | 1 | Synchronous hard reset event, ignored in suspend |
| suspendPin | input | 1 | Asynchronous suspend request pin |
| modeReq | input | 3 | Low-power request bits: [0] doze, [1] nap, [2] sleep |
| sleepRefreshEn | input | 1 | Keep refresh running during sleep |
| busBusy | input | 1 | A transaction is outstanding |
| pciMemHit | input | 1 | PCI transaction decoded to system memory |
| cpuBusReq | input | 1 | Processor bus request |
| accessDone | input | 1 | The access serviced after a wake has completed |
| curMode | output | 3 | Current power mode code |
| enPciDecode | output | 1 | Enable for PCI address decoding |
| enRefresh | output | 1 | Enable for DRAM refresh |
| enBusReqMon | output | 1 | Enable for bus-request monitoring |
| enCore | output | 1 | Enable for the rest of the core |
| quiesceAck | output | 1 | Quiesce acknowledge |
| outHiZ | output | 1 | Release all outputs to high impedance |

## Verification
The bench builds the block with IDLE_CYCLES set to 3 and SYNC_STAGES set to 2. With these values the idle-window deferral is short enough to check edge by edge: no entry on the second idle edge, entry on the third. The two-flop suspend latency can likewise be observed exactly, both on entry and on release. The small idle window also lets each wake scenario rearm and re-enter a mode within a handful of cycles, so every exit path is exercised in turn: doze, nap by PCI, nap by processor, sleep by processor, hard reset and suspend.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    MODE_FULL    = 3'd0,
    MODE_DOZE    = 3'd1,
    MODE_NAP     = 3'd2,
    MODE_SLEEP   = 3'd3,
    MODE_SUSPEND = 3'd4,
    MODE_SERVICE = 3'd5
  } pwrMode_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    pwrMode_e nextMode;    // mode taking effect at this edge
    logic     captureWake; // latch wake origin and the mode to return to
    logic     wakeIsCpu;   // origin of the wake being captured
    pwrMode_e lowMode;     // low-power mode left by the wake
    logic     disarm;      // clear the request arm
  } pwrStrobes_t;

  // Request priority: sleep over nap over doze
  function automatic pwrMode_e pickMode(input logic [2:0] req);
    if (req[2])      return MODE_SLEEP;
    else if (req[1]) return MODE_NAP;
    else             return MODE_DOZE;
  endfunction

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int IDLE_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  pwrStrobes_t strobes,
  input  logic [2:0]  modeReq,
  input  logic        busBusy,
  input  logic        sleepRefreshEn,
  input  logic        suspendPin,
  output logic        suspendSync,
  output logic        armed,
  output logic        idleReady,
  output pwrMode_e    retMode,
  output logic        wakeCpu,
  output logic        enPciDecode,
  output logic        enRefresh,
  output logic        enBusReqMon,
  output logic        enCore,
  output logic        quiesceAck,
  output logic        outHiZ
);

  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(IDLE_CYCLES - 1);

  // Suspend pin synchronizer; depth picks the variant
  logic [SYNC_STAGES-1:0] syncChain;
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= suspendPin;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], suspendPin};
      end
    end
  endgenerate
  assign suspendSync = syncChain[SYNC_STAGES-1];

  // Consecutive idle-cycle counter, counted only while staying full-on
  logic [CNT_W-1:0] idleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobes.nextMode != MODE_FULL || busBusy) begin
      idleCnt <= '0;
    end else if (idleCnt != CNT_TOP) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end
  assign idleReady = (idleCnt == CNT_TOP);

  // Request arm: set when all request bits read zero; disarm wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               armed <= 1'b0;
    else if (strobes.disarm) armed <= 1'b0;
    else if (modeReq == '0)  armed <= 1'b1;
  end

  // Wake context
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retMode <= MODE_FULL;
      wakeCpu <= 1'b0;
    end else if (strobes.captureWake) begin
      retMode <= strobes.lowMode;
      wakeCpu <= strobes.wakeIsCpu;
    end
  end

  // Group enables registered from the mode taking effect
  logic [5:0] enNext; // {pci, refresh, mon, core, ack, hiz}
  always_comb begin
    case (strobes.nextMode)
      MODE_DOZE:    enNext = 6'b111000;
      MODE_NAP:     enNext = 6'b111010;
      MODE_SLEEP:   enNext = {1'b0, sleepRefreshEn, 4'b0010};
      MODE_SUSPEND: enNext = 6'b010001;
      default:      enNext = 6'b111100;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {enPciDecode, enRefresh, enBusReqMon, enCore, quiesceAck, outHiZ} <= 6'b111100;
    end else begin
      {enPciDecode, enRefresh, enBusReqMon, enCore, quiesceAck, outHiZ} <= enNext;
    end
  end

  // Suspend keeps refresh alive and releases the outputs
  assert_suspend_outputs_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.nextMode == MODE_SUSPEND) |=> (outHiZ && enRefresh && !enCore));

  // A wake into service always lights the core
  assert_service_core_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.nextMode == MODE_SERVICE) |=> (enCore && enPciDecode && enBusReqMon));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hardRst,
  input  logic        suspendSync,
  input  logic [2:0]  modeReq,
  input  logic        busBusy,
  input  logic        pciMemHit,
  input  logic        cpuBusReq,
  input  logic        accessDone,
  input  logic        armed,
  input  logic        idleReady,
  input  pwrMode_e    retMode,
  input  logic        wakeCpu,
  output pwrStrobes_t strobes,
  output pwrMode_e    curMode
);

  pwrMode_e state;

  always_comb begin
    strobes = '{nextMode: state, captureWake: 1'b0, wakeIsCpu: 1'b0,
                lowMode: MODE_FULL, disarm: 1'b0};
    if (suspendSync) begin
      strobes.nextMode = MODE_SUSPEND;
    end else if (state == MODE_SUSPEND) begin
      strobes.nextMode = MODE_FULL;
      strobes.disarm   = 1'b1;
    end else if (hardRst) begin
      strobes.nextMode = MODE_FULL;
      strobes.disarm   = 1'b1;
    end else begin
      case (state)
        MODE_FULL: begin
          if (armed && modeReq != '0 && idleReady && !busBusy)
            strobes.nextMode = pickMode(modeReq);
        end
        MODE_DOZE, MODE_NAP: begin
          if (pciMemHit || cpuBusReq) begin
            strobes.nextMode    = MODE_SERVICE;
            strobes.captureWake = 1'b1;
            strobes.wakeIsCpu   = cpuBusReq;
            strobes.lowMode     = state;
          end
        end
        MODE_SLEEP: begin
          if (cpuBusReq) begin
            strobes.nextMode = MODE_FULL;
            strobes.disarm   = 1'b1;
          end
        end
        MODE_SERVICE: begin
          if (accessDone) begin
            if (modeReq == '0) begin
              strobes.nextMode = MODE_FULL;
            end else if (retMode == MODE_NAP && wakeCpu) begin
              strobes.nextMode = MODE_FULL;
              strobes.disarm   = 1'b1;
            end else begin
              strobes.nextMode = retMode;
            end
          end
        end
        default: strobes.nextMode = MODE_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_FULL;
    else       state <= strobes.nextMode;
  end

  assign curMode = state;

  // No low-power entry on an edge where a transaction is outstanding
  assert_defer_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_FULL && busBusy) |=>
      !(state inside {MODE_DOZE, MODE_NAP, MODE_SLEEP}));

  // Sleep request dominates the lighter modes
  assert_sleep_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_FULL && modeReq[2]) |=> !(state inside {MODE_DOZE, MODE_NAP}));

  // PCI traffic does not wake sleep
  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_SLEEP && !cpuBusReq && !hardRst && !suspendSync) |=>
      (state == MODE_SLEEP));

  // Hard reset is ignored while suspended
  assert_suspend_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == MODE_SUSPEND && suspendSync) |=> (state == MODE_SUSPEND));

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int IDLE_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hardRst,
  input  logic       suspendPin,
  input  logic [2:0] modeReq,
  input  logic       sleepRefreshEn,
  input  logic       busBusy,
  input  logic       pciMemHit,
  input  logic       cpuBusReq,
  input  logic       accessDone,
  output logic [2:0] curMode,
  output logic       enPciDecode,
  output logic       enRefresh,
  output logic       enBusReqMon,
  output logic       enCore,
  output logic       quiesceAck,
  output logic       outHiZ
);

  pwrStrobes_t strobes;
  pwrMode_e    modeNow;
  pwrMode_e    retMode;
  logic        suspendSync;
  logic        armed;
  logic        idleReady;
  logic        wakeCpu;

  pwr_mode_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .hardRst     (hardRst),
    .suspendSync (suspendSync),
    .modeReq     (modeReq),
    .busBusy     (busBusy),
    .pciMemHit   (pciMemHit),
    .cpuBusReq   (cpuBusReq),
    .accessDone  (accessDone),
    .armed       (armed),
    .idleReady   (idleReady),
    .retMode     (retMode),
    .wakeCpu     (wakeCpu),
    .strobes     (strobes),
    .curMode     (modeNow)
  );

  pwr_mode_dp #(
    .IDLE_CYCLES (IDLE_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .modeReq        (modeReq),
    .busBusy        (busBusy),
    .sleepRefreshEn (sleepRefreshEn),
    .suspendPin     (suspendPin),
    .suspendSync    (suspendSync),
    .armed          (armed),
    .idleReady      (idleReady),
    .retMode        (retMode),
    .wakeCpu        (wakeCpu),
    .enPciDecode    (enPciDecode),
    .enRefresh      (enRefresh),
    .enBusReqMon    (enBusReqMon),
    .enCore         (enCore),
    .quiesceAck     (quiesceAck),
    .outHiZ         (outHiZ)
  );

  assign curMode = modeNow;

  // Acknowledge tracks the two deep states exactly
  assert_ack_deep_R11: assert property (@(posedge clk) disable iff (!rstN)
    quiesceAck == (modeNow == MODE_NAP || modeNow == MODE_SLEEP));

  // Light modes keep only the three watch groups
  assert_light_groups_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == MODE_DOZE || modeNow == MODE_NAP) |->
      (!enCore && enPciDecode && enRefresh && enBusReqMon));

endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hardRst = 1'b0;
  logic       suspendPin = 1'b0;
  logic [2:0] modeReq = 3'b000;
  logic       sleepRefreshEn = 1'b1;
  logic       busBusy = 1'b0;
  logic       pciMemHit = 1'b0;
  logic       cpuBusReq = 1'b0;
  logic       accessDone = 1'b0;
  logic [2:0] curMode;
  logic       enPciDecode, enRefresh, enBusReqMon, enCore, quiesceAck, outHiZ;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.IDLE_CYCLES(3), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .hardRst(hardRst), .suspendPin(suspendPin),
    .modeReq(modeReq), .sleepRefreshEn(sleepRefreshEn), .busBusy(busBusy),
    .pciMemHit(pciMemHit), .cpuBusReq(cpuBusReq), .accessDone(accessDone),
    .curMode(curMode), .enPciDecode(enPciDecode), .enRefresh(enRefresh),
    .enBusReqMon(enBusReqMon), .enCore(enCore), .quiesceAck(quiesceAck),
    .outHiZ(outHiZ)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock edge, then sample at the falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // outputs packed {pci, refresh, mon, core, ack, hiz}
  task automatic chkOut(input string req, input int mode, input int outs);
    chk(req, "curMode", int'(curMode), mode);
    chk(req, "groups", int'({enPciDecode, enRefresh, enBusReqMon, enCore, quiesceAck, outHiZ}), outs);
  endtask

  task automatic settleFull();
    modeReq = 3'b000; busBusy = 1'b0; hardRst = 1'b1;
    step(1);
    hardRst = 1'b0;
    step(4);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    step(2);
    rstN = 1'b1;
    chkOut("R1", 0, 6'b111100);
    step(4);
    chkOut("R12", 0, 6'b111100);
  endtask

  task automatic testPriority();
    settleFull();
    sleepRefreshEn = 1'b1;
    modeReq = 3'b111;
    step(1);
    chkOut("R2", 3, 6'b010010);
    hardRst = 1'b1;
    step(1);
    hardRst = 1'b0;
    chkOut("R10", 0, 6'b111100);
    step(3); // still requested but disarmed
    chk("R10", "stay full", int'(curMode), 0);
    settleFull();
    modeReq = 3'b011;
    step(1);
    chkOut("R2", 2, 6'b111010);
  endtask

  task automatic testDoze();
    settleFull();
    modeReq = 3'b001;
    step(1);
    chkOut("R4", 1, 6'b111000);
    pciMemHit = 1'b1;
    step(1);
    pciMemHit = 1'b0;
    chkOut("R6", 5, 6'b111100);
    step(2);
    chk("R6", "hold service", int'(curMode), 5);
    accessDone = 1'b1;
    step(1);
    accessDone = 1'b0;
    chk("R6", "back to doze after pci", int'(curMode), 1);
    cpuBusReq = 1'b1;
    step(1);
    cpuBusReq = 1'b0;
    chk("R6", "cpu wake", int'(curMode), 5);
    accessDone = 1'b1;
    step(1);
    accessDone = 1'b0;
    chk("R6", "back to doze after cpu", int'(curMode), 1);
    pciMemHit = 1'b1;
    step(1);
    pciMemHit = 1'b0;
    modeReq = 3'b000;
    accessDone = 1'b1;
    step(1);
    accessDone = 1'b0;
    chkOut("R6", 0, 6'b111100);
  endtask

  task automatic testNap();
    settleFull();
    modeReq = 3'b010;
    step(1);
    chkOut("R11", 2, 6'b111010);
    pciMemHit = 1'b1;
    step(1);
    pciMemHit = 1'b0;
    chk("R11", "ack drops in service", int'(quiesceAck), 0);
    accessDone = 1'b1;
    step(1);
    accessDone = 1'b0;
    chk("R7", "pci wake returns nap", int'(curMode), 2);
    cpuBusReq = 1'b1;
    pciMemHit = 1'b1;
    step(1);
    cpuBusReq = 1'b0;
    pciMemHit = 1'b0;
    accessDone = 1'b1;
    step(1);
    accessDone = 1'b0;
    chkOut("R7", 0, 6'b111100);
    step(4);
    chk("R7", "disarmed stays full", int'(curMode), 0);
    modeReq = 3'b000;
    step(1);
    modeReq = 3'b010;
    step(1);
    chk("R7", "rearmed nap", int'(curMode), 2);
  endtask

  task automatic testSleep();
    settleFull();
    sleepRefreshEn = 1'b0;
    modeReq = 3'b100;
    step(1);
    chkOut("R5", 3, 6'b000010);
    pciMemHit = 1'b1;
    step(2);
    pciMemHit = 1'b0;
    chkOut("R8", 3, 6'b000010);
    cpuBusReq = 1'b1;
    step(1);
    cpuBusReq = 1'b0;
    chkOut("R8", 0, 6'b111100);
    sleepRefreshEn = 1'b1;
  endtask

  task automatic testDefer();
    settleFull();
    busBusy = 1'b1;
    modeReq = 3'b001;
    step(5);
    chk("R3", "busy holds full", int'(curMode), 0);
    busBusy = 1'b0;
    step(2);
    chk("R3", "second idle edge", int'(curMode), 0);
    step(1);
    chk("R3", "third idle edge", int'(curMode), 1);
  endtask

  task automatic testSuspend();
    settleFull();
    modeReq = 3'b010;
    step(1);
    chk("R9", "nap before suspend", int'(curMode), 2);
    suspendPin = 1'b1;
    step(2);
    chk("R9", "sync latency", int'(curMode), 2);
    step(1);
    chkOut("R9", 4, 6'b010001);
    hardRst = 1'b1;
    cpuBusReq = 1'b1;
    step(2);
    hardRst = 1'b0;
    cpuBusReq = 1'b0;
    chkOut("R9", 4, 6'b010001);
    suspendPin = 1'b0;
    step(2);
    chk("R9", "release latency", int'(curMode), 4);
    step(1);
    chkOut("R9", 0, 6'b111100);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testPriority();
    testDoze();
    testNap();
    testSleep();
    testDefer();
    testSuspend();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule